// File: doc/BRIEF.md
# Masked Packed FMA Lane Controller

This block does the steering and write-back control around a bank of single-precision fused multiply-add units that work on packed vectors of 4, 8 or 16 elements, each 32 bits wide. An operand-order code chooses which of the destination vector and the two source vectors go to the multiplier inputs and which goes to the addend. The third source may be replaced, in every lane, by its element 0. The block also picks the rounding mode that the arithmetic bank uses. When results come back, each lane is written or masked, and masked lanes either keep their old value or are cleared. Every lane above the selected vector length is forced to zero. The block ORs the exception flags of the lanes that were actually written.

The arithmetic bank sits outside this block. The block drives its operand buses and rounding mode from the current input beat, and reads its result and flag buses back in the same cycle. One operation enters through a valid/ready input beat. The write-back result appears on a valid/ready output register one cycle after the input beat is accepted. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its data and flags unchanged, and no new beat is accepted.

Top module: `fma_lane_ctl`

## Requirements
- R1: Order code 0 sends dest to multiplier input A, src3 to multiplier input B and src2 to the addend.
- R2: Order code 1 sends src2 to input A, dest to input B and src3 to the addend.
- R3: Order code 2 sends src2 to input A, src3 to input B and dest to the addend. Code 3 behaves the same as code 2.
- R4: When `src3_mem` and `bcast` are both 1, bits [31:0] of src3 stand in for the src3 element of every lane. Otherwise lane j uses src3 bits [32j+31:32j].
- R5: Length code 0, 1 and 2 selects 4, 8 and 16 active lanes, and code 3 acts as code 2. Lane j occupies bits [32j+31:32j]. Every output bit of an inactive lane is 0.
- R6: `out_flags` (5 bits) is the OR of the per-lane flag fields, taking only active lanes that are written. All other lanes add nothing.
- R7: An active lane is written with the bank result when `mask_en` is 0 or its `kmask` bit is 1. Otherwise it outputs its dest element when `zero_mode` is 0, or 0 when `zero_mode` is 1.
- R8: `fma_rm` equals `static_rm` when `src3_mem` is 0, `bcast` is 1 and the length code is 2 or 3. In every other case it equals `global_rm`.
- R9: An accepted input beat produces `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, `out_data` and `out_flags` stay stable and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be accepted |
| order | input | 2 | Operand-order code |
| vlen | input | 2 | Vector length code |
| mask_en | input | 1 | Enable per-lane masking |
| zero_mode | input | 1 | Masked lanes cleared (1) or merged (0) |
| src3_mem | input | 1 | Third source comes from memory |
| bcast | input | 1 | Broadcast / static-rounding control bit |
| static_rm | input | 2 | Rounding mode carried by the operation |
| global_rm | input | 2 | Rounding mode from the global control register |
| kmask | input | 16 | Per-lane write mask |
| dest | input | 512 | Destination vector (old value, first source) |
| src2 | input | 512 | Second source vector |
| src3 | input | 512 | Third source vector |
| fma_a | output | 512 | Multiplier input A for each lane |
| fma_b | output | 512 | Multiplier input B for each lane |
| fma_c | output | 512 | Addend for each lane |
| fma_rm | output | 2 | Rounding mode sent to the bank |
| fma_res | input | 512 | Per-lane results returned by the bank |
| fma_flags | input | 80 | Per-lane 5-bit exception flags returned by the bank |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take the output beat |
| out_data | output | 512 | Written-back vector |
| out_flags | output | 5 | Merged exception flags |

## Verification
Each order code, code 3 included, is driven with random vectors and no masking. The bench FMA stand-in computes a*b+c+rm, so any swap between multiplier and addend roles, and any wrong rounding choice, changes the value. Merge and zero masking use the same random masks, which separates kept lanes from cleared lanes. Every length code is tried, which exposes stray data in the upper lanes. Broadcast is tried with a memory third source and with a register third source at 512 and at 256 bits. These cases tell the element-0 substitution apart from the rounding override. A fully masked beat checks that masked lanes contribute no flags, and random output stalls test holding under back-pressure.

// File: rtl/fma_ctl_pkg.sv
package fma_ctl_pkg;
  localparam int LANE_W = 32;
  localparam int FLAG_W = 5;

  typedef enum logic [1:0] {
    ORD_DS3_S2 = 2'd0,
    ORD_S2D_S3 = 2'd1,
    ORD_S2S3_D = 2'd2,
    ORD_ALT    = 2'd3
  } order_e;
endpackage

// File: rtl/fma_lane_steer.sv
module fma_lane_steer
  import fma_ctl_pkg::*;
#(
  parameter int LANES = 16,
  localparam int VW = LANES * LANE_W
) (
  input  logic [1:0]    order,
  input  logic          bcast_en,
  input  logic [VW-1:0] dest,
  input  logic [VW-1:0] src2,
  input  logic [VW-1:0] src3,
  output logic [VW-1:0] mul_a,
  output logic [VW-1:0] mul_b,
  output logic [VW-1:0] add_c
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] d_e, s2_e, s3_e;
    assign d_e  = dest[l*LANE_W +: LANE_W];
    assign s2_e = src2[l*LANE_W +: LANE_W];
    // element 0 of src3 replaces the lane element on broadcast
    assign s3_e = bcast_en ? src3[LANE_W-1:0] : src3[l*LANE_W +: LANE_W];

    always_comb begin
      case (order_e'(order))
        ORD_DS3_S2: begin
          mul_a[l*LANE_W +: LANE_W] = d_e;
          mul_b[l*LANE_W +: LANE_W] = s3_e;
          add_c[l*LANE_W +: LANE_W] = s2_e;
        end
        ORD_S2D_S3: begin
          mul_a[l*LANE_W +: LANE_W] = s2_e;
          mul_b[l*LANE_W +: LANE_W] = d_e;
          add_c[l*LANE_W +: LANE_W] = s3_e;
        end
        default: begin
          mul_a[l*LANE_W +: LANE_W] = s2_e;
          mul_b[l*LANE_W +: LANE_W] = s3_e;
          add_c[l*LANE_W +: LANE_W] = d_e;
        end
      endcase
    end
  end
endmodule

// File: rtl/fma_lane_wb.sv
module fma_lane_wb
  import fma_ctl_pkg::*;
#(
  parameter int LANES = 16,
  localparam int VW = LANES * LANE_W,
  localparam int FW = LANES * FLAG_W,
  localparam int MIN_LANES = LANES / 4,
  localparam int CNT_W = $clog2(LANES) + 1
) (
  input  logic [1:0]        vlen,
  input  logic              mask_en,
  input  logic              zero_mode,
  input  logic [LANES-1:0]  kmask,
  input  logic [VW-1:0]     dest,
  input  logic [VW-1:0]     res,
  input  logic [FW-1:0]     lane_flags,
  output logic [VW-1:0]     wb_data,
  output logic [FLAG_W-1:0] wb_flags
);
  logic [CNT_W-1:0] act_cnt;
  logic [LANES-1:0] lane_wr;

  // length codes 2 and 3 both select the full width
  assign act_cnt = vlen[1] ? CNT_W'(LANES)
                           : (CNT_W'(MIN_LANES) << vlen[0]);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic active;
    assign active     = CNT_W'(l) < act_cnt;
    assign lane_wr[l] = active && (!mask_en || kmask[l]);

    always_comb begin
      if (!active)
        wb_data[l*LANE_W +: LANE_W] = '0;
      else if (lane_wr[l])
        wb_data[l*LANE_W +: LANE_W] = res[l*LANE_W +: LANE_W];
      else if (zero_mode)
        wb_data[l*LANE_W +: LANE_W] = '0;
      else
        wb_data[l*LANE_W +: LANE_W] = dest[l*LANE_W +: LANE_W];
    end
  end

  always_comb begin
    wb_flags = '0;
    for (int l = 0; l < LANES; l++)
      if (lane_wr[l]) wb_flags |= lane_flags[l*FLAG_W +: FLAG_W];
  end
endmodule

// File: rtl/fma_lane_ctl.sv
module fma_lane_ctl
  import fma_ctl_pkg::*;
#(
  parameter int LANES = 16,
  localparam int VW = LANES * LANE_W,
  localparam int FW = LANES * FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        order,
  input  logic [1:0]        vlen,
  input  logic              mask_en,
  input  logic              zero_mode,
  input  logic              src3_mem,
  input  logic              bcast,
  input  logic [1:0]        static_rm,
  input  logic [1:0]        global_rm,
  input  logic [LANES-1:0]  kmask,
  input  logic [VW-1:0]     dest,
  input  logic [VW-1:0]     src2,
  input  logic [VW-1:0]     src3,
  output logic [VW-1:0]     fma_a,
  output logic [VW-1:0]     fma_b,
  output logic [VW-1:0]     fma_c,
  output logic [1:0]        fma_rm,
  input  logic [VW-1:0]     fma_res,
  input  logic [FW-1:0]     fma_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VW-1:0]     out_data,
  output logic [FLAG_W-1:0] out_flags
);
  logic              accept;
  logic [VW-1:0]     wb_data;
  logic [FLAG_W-1:0] wb_flags;
  logic [1:0]        len_q;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  // register-source full-width beat with the control bit: static rounding
  assign fma_rm   = (!src3_mem && bcast && vlen[1]) ? static_rm : global_rm;

  fma_lane_steer #(.LANES(LANES)) steer_i (
    .order    (order),
    .bcast_en (src3_mem && bcast),
    .dest     (dest),
    .src2     (src2),
    .src3     (src3),
    .mul_a    (fma_a),
    .mul_b    (fma_b),
    .add_c    (fma_c)
  );

  fma_lane_wb #(.LANES(LANES)) wb_i (
    .vlen       (vlen),
    .mask_en    (mask_en),
    .zero_mode  (zero_mode),
    .kmask      (kmask),
    .dest       (dest),
    .res        (fma_res),
    .lane_flags (fma_flags),
    .wb_data    (wb_data),
    .wb_flags   (wb_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_flags <= '0;
      len_q     <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= wb_data;
      out_flags <= wb_flags;
      len_q     <= vlen;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_flags)); // R9
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R9
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && len_q == 2'd0 |-> out_data[VW-1:VW/4] == '0); // R5
  AST_NO_MASKED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mask_en && kmask == '0 |=> out_flags == '0); // R6
  AST_BCAST_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && src3_mem && bcast && order == 2'd2 |-> fma_b[2*LANE_W-1:LANE_W] == src3[LANE_W-1:0]); // R4
  AST_MEM_GLOBAL_RM: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && src3_mem |-> fma_rm == global_rm); // R8
endmodule

// File: tb/fma_lane_ctl_tb_top.sv
module fma_lane_ctl_tb_top;
  localparam int L = 16;
  localparam int VW = L * 32;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [1:0] order = 0, vlen = 0, static_rm = 0, global_rm = 0;
  logic mask_en = 0, zero_mode = 0, src3_mem = 0, bcast = 0;
  logic [L-1:0] kmask = 0;
  logic [VW-1:0] dest = 0, src2 = 0, src3 = 0;
  logic [VW-1:0] fma_a, fma_b, fma_c, fma_res;
  logic [1:0] fma_rm;
  logic [L*5-1:0] fma_flags;
  logic out_valid, out_ready = 1;
  logic [VW-1:0] out_data;
  logic [4:0] out_flags;

  int n_chk = 0, n_fail = 0;
  logic [VW-1:0] exp_d_q[$];
  logic [4:0]    exp_f_q[$];
  string         tag_q[$];
  string         cur_tag = "R9";
  bit            stall_rand = 0;

  always #10 clk = ~clk;

  fma_lane_ctl dut_i (.*);

  // bench stand-in for the arithmetic bank: a*b+c+rm, flags = low 5 bits of a
  always_comb begin
    for (int j = 0; j < L; j++) begin
      fma_res[j*32 +: 32] = fma_a[j*32 +: 32] * fma_b[j*32 +: 32]
                          + fma_c[j*32 +: 32] + 32'(fma_rm);
      fma_flags[j*5 +: 5] = fma_a[j*32 +: 5];
    end
  end

  task automatic check(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // behavioural reference of one beat, computed from the current inputs
  task automatic model(output logic [VW-1:0] d, output logic [4:0] f);
    int n;
    logic [1:0] rm;
    logic [31:0] a, b, c, s3;
    n  = (vlen >= 2) ? 16 : (vlen == 1 ? 8 : 4);
    rm = (!src3_mem && bcast && vlen >= 2) ? static_rm : global_rm;
    d = '0; f = '0;
    for (int j = 0; j < n; j++) begin
      s3 = (src3_mem && bcast) ? src3[31:0] : src3[j*32 +: 32];
      if (order == 0) begin a = dest[j*32 +: 32]; b = s3; c = src2[j*32 +: 32]; end
      else if (order == 1) begin a = src2[j*32 +: 32]; b = dest[j*32 +: 32]; c = s3; end
      else begin a = src2[j*32 +: 32]; b = s3; c = dest[j*32 +: 32]; end
      if (!mask_en || kmask[j]) begin
        d[j*32 +: 32] = a * b + c + 32'(rm);
        f |= a[4:0];
      end else if (!zero_mode) d[j*32 +: 32] = dest[j*32 +: 32];
    end
  endtask

  // monitor at the falling edge: predicts accepted beats, compares drained beats
  always @(negedge clk) begin
    logic [VW-1:0] ed;
    logic [4:0] ef;
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (exp_d_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R9 act=unexpected output exp=none");
        end else begin
          string t;
          t = tag_q.pop_front();
          check(t, out_data, exp_d_q.pop_front());
          check({t, " R6 flags"}, VW'(out_flags), VW'(exp_f_q.pop_front()));
        end
      end
      if (out_valid && !out_ready) begin : hold
        n_chk++;
        if (in_ready) begin
          n_fail++;
          $display("FAIL R9 act=in_ready 1 exp=0");
        end
      end
      if (in_valid && in_ready) begin
        model(ed, ef);
        exp_d_q.push_back(ed);
        exp_f_q.push_back(ef);
        tag_q.push_back(cur_tag);
      end
    end
  end

  always @(posedge clk) begin
    #3;
    if (stall_rand) out_ready <= ($urandom_range(0, 2) != 0);
    else out_ready <= 1'b1;
  end

  function automatic logic [VW-1:0] rvec();
    logic [VW-1:0] v;
    for (int j = 0; j < L; j++) v[j*32 +: 32] = $urandom();
    return v;
  endfunction

  task automatic send(string tag, logic [1:0] o, logic [1:0] vl, logic me, logic zm,
                      logic mem, logic bc, logic [L-1:0] k);
    bit acc;
    @(posedge clk); #3;
    cur_tag = tag;
    order = o; vlen = vl; mask_en = me; zero_mode = zm; src3_mem = mem; bcast = bc;
    kmask = k; dest = rvec(); src2 = rvec(); src3 = rvec();
    static_rm = 2'($urandom_range(1, 3)); global_rm = 2'($urandom_range(0, 3));
    if (static_rm == global_rm) global_rm = static_rm + 2'd1;
    in_valid = 1;
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #3;
    end while (!acc);
    in_valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset out_valid", VW'(out_valid), '0);
    check("R9 reset in_ready", VW'(in_ready), VW'(1));
    @(posedge clk); #3; rst_n = 1;
    send("R1 order 0", 0, 2, 0, 0, 0, 0, '0);
    send("R2 order 1", 1, 2, 0, 0, 0, 0, '0);
    send("R3 order 2", 2, 2, 0, 0, 0, 0, '0);
    send("R3 order 3", 3, 2, 0, 0, 0, 0, '0);
    send("R7 merge", 0, 2, 1, 0, 0, 0, 16'hA5C3);
    send("R7 zero", 1, 2, 1, 1, 0, 0, 16'hA5C3);
    send("R5 len 4", 2, 0, 0, 0, 0, 0, '0);
    send("R5 len 8", 0, 1, 1, 0, 0, 0, 16'hFF0F);
    send("R5 len code 3", 1, 3, 0, 0, 0, 0, '0);
    send("R4 bcast mem", 2, 2, 0, 0, 1, 1, '0);
    send("R4 bcast mem order 1", 1, 1, 0, 0, 1, 1, '0);
    send("R8 static rm 512", 0, 2, 0, 0, 0, 1, '0);
    send("R8 no override 256", 0, 1, 0, 0, 0, 1, '0);
    send("R6 all masked", 2, 2, 1, 0, 0, 0, '0);
    send("R6 all masked zero", 2, 2, 1, 1, 0, 0, '0);
    stall_rand = 1;
    for (int i = 0; i < 40; i++)
      send("R9 stall mix", 2'(i), 2'(i >> 2), 1'(i >> 1), 1'(i >> 3), 1'(i >> 2), 1'(i), 16'($urandom()));
    stall_rand = 0;
    repeat (6) @(posedge clk);
    if (exp_d_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R9 act=%0d pending exp=0", exp_d_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 act=watchdog expired exp=run complete");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule